// File: doc/BRIEF.md
# Watchdog Escalation Controller

This block decides what happens after a watchdog reports that a feed was missed. It does not reset the system on the first missed feed. It raises an interrupt so firmware can try a soft recovery, such as flushing logs or unmounting storage. It then waits a bounded window for a healthy feed. If no feed arrives, it starts another attempt after a backoff window that grows linearly or exponentially. When the attempts run out, it asks for a hard reset.

A total time budget caps the whole recovery sequence. A brown-out during recovery cuts the sequence short and forces the reset at once. A direct mode skips the interrupt stage altogether, for hangs that cannot be recovered. The controller records why it escalated in a cause register, which holds its value until software clears it. The timeout counter that produces the missed-feed event is not part of this block, and neither is the stretching of the reset pulse.

Top module: `wdt_escalator`

## Requirements
- R1: After reset, irq, hard_reset_req, retry_cnt and reset_cause are all 0.
- R2: A timeout_evt seen while idle (retry_cnt 0) with cfg_direct low has the following result on the next cycle: irq is 1, retry_cnt is 1 and hard_reset_req is 0.
- R3: Each attempt k has a window length that depends on the backoff mode:
  - linear mode (cfg_exp=0): cfg_base*k;
  - exponential mode (cfg_exp=1): cfg_base*2^(k-1).
  - In both modes, a cfg_base of 0 acts as 1, and the length saturates at 2^CNT_W-1.
  - Windows are counted in clock edges after the edge that accepted the event.
  - When a window ends without escalation, retry_cnt increments and irq is driven to 1.
- R4: When the window of attempt max(1,cfg_max_retry) ends, hard_reset_req pulses and reset_cause becomes 1 (attempts exhausted).
- R5: The budget expires max(1,cfg_budget) edges after entry. At that edge hard_reset_req pulses and reset_cause becomes 2 (budget expired). Budget expiry wins over a window end on the same edge.
- R6: brownout while recovering (retry_cnt nonzero) gives hard_reset_req on the next cycle with reset_cause 3. Brownout wins over feed_ok on the same edge. While idle, brownout has no effect.
- R7: feed_ok while recovering (and no brownout) returns the block to idle on the next cycle: retry_cnt 0, irq 0, no reset request. It wins over budget expiry and window end on the same edge. While idle, feed_ok has no effect.
- R8: With cfg_direct high, a timeout_evt while idle gives hard_reset_req on the next cycle with reset_cause 4 and irq 0.
- R9: hard_reset_req is high for exactly one cycle. While it is high, retry_cnt is 0 and irq is 0.
- R10: reset_cause holds its value until cause_clr. After cause_clr it reads 0 on the next cycle, unless a new cause is written on the same edge; the new cause wins.
- R11: irq stays at 1 until irq_ack. irq_ack clears it on the next cycle, unless a new attempt starts on the same edge.
- R12: timeout_evt has no effect while recovering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timeout_evt | input | 1 | Missed-feed event from the watchdog counter |
| feed_ok | input | 1 | Healthy feed observed |
| brownout | input | 1 | Supply unstable |
| cfg_direct | input | 1 | 1: escalate straight to hard reset |
| cfg_exp | input | 1 | Backoff mode: 0 linear, 1 exponential |
| cfg_max_retry | input | RETRY_W | Attempt limit (0 acts as 1) |
| cfg_base | input | CNT_W | Base window in cycles (0 acts as 1) |
| cfg_budget | input | BUD_W | Total recovery budget in cycles (0 acts as 1) |
| irq_ack | input | 1 | Interrupt acknowledge |
| cause_clr | input | 1 | Clear reset_cause |
| irq | output | 1 | Soft-recovery interrupt |
| hard_reset_req | output | 1 | One-cycle hard reset request |
| retry_cnt | output | RETRY_W | Current attempt number, 0 when idle |
| reset_cause | output | 3 | Escalation cause: 0 none, 1 exhausted, 2 budget, 3 brown-out, 4 direct |

## Verification
The bench aims at edges where two conditions meet:
- A budget that ends on the same edge as the final window; a design with the wrong priority would report the exhausted cause instead of the budget cause.
- A feed on the very edge that would escalate; a design with the wrong priority would issue a spurious reset.
- Brown-out and feed on the same edge; a design with the wrong priority would return to idle instead of escalating.

It also targets these cases:
- Exponential windows that saturate; a design without saturation would wrap and escalate far too early.
- A limit of zero and a base of zero; a design that took them literally would hang or escalate at once.
- A cause clear that coincides with a new cause; a design that let the clear win would lose the cause record.
- Acknowledges that land on an attempt start; a design that let the acknowledge win would drop the new interrupt.

// File: rtl/wdt_esc_pkg.sv
package wdt_esc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } esc_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_EXHAUST = 3'd1,
        CAUSE_BUDGET  = 3'd2,
        CAUSE_BROWN   = 3'd3,
        CAUSE_DIRECT  = 3'd4
    } esc_cause_e;

endpackage

// File: rtl/wdt_esc_backoff.sv
module wdt_esc_backoff #(
    parameter int CNT_W = 16
) (
    input  logic             mode_exp,
    input  logic [CNT_W-1:0] cur_win,
    input  logic [CNT_W-1:0] base_win,
    output logic [CNT_W-1:0] next_win
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W:0]   lin_sum;
    logic [CNT_W-1:0] lin_win;
    logic [CNT_W-1:0] exp_win;

    always_comb begin
        lin_sum = {1'b0, cur_win} + {1'b0, base_win};
        lin_win = lin_sum[CNT_W] ? SAT : lin_sum[CNT_W-1:0];
        exp_win = cur_win[CNT_W-1] ? SAT : {cur_win[CNT_W-2:0], 1'b0};
        next_win = mode_exp ? exp_win : lin_win;
    end

endmodule

// File: rtl/wdt_esc_cause.sv
module wdt_esc_cause
    import wdt_esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_vld,
    input  esc_cause_e set_code,
    input  logic       clr,
    output esc_cause_e cause
);
    esc_cause_e cause_d, cause_q;

    always_comb begin
        cause_d = cause_q;
        if (clr)     cause_d = CAUSE_NONE;
        if (set_vld) cause_d = set_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= CAUSE_NONE;
        else        cause_q <= cause_d;
    end

    assign cause = cause_q;

endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
    import wdt_esc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RETRY_W = 3,
    parameter int BUD_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               timeout_evt,
    input  logic               feed_ok,
    input  logic               brownout,
    input  logic               cfg_direct,
    input  logic               cfg_exp,
    input  logic [RETRY_W-1:0] cfg_max_retry,
    input  logic [CNT_W-1:0]   cfg_base,
    input  logic [BUD_W-1:0]   cfg_budget,
    input  logic               irq_ack,
    input  logic               cause_clr,
    output logic               irq,
    output logic               hard_reset_req,
    output logic [RETRY_W-1:0] retry_cnt,
    output logic [2:0]         reset_cause
);
    localparam logic [CNT_W-1:0]   WIN_ONE = CNT_W'(1);
    localparam logic [RETRY_W-1:0] RTY_ONE = RETRY_W'(1);
    localparam logic [BUD_W-1:0]   BUD_ONE = BUD_W'(1);
    localparam logic [BUD_W:0]     INC_ONE = (BUD_W + 1)'(1);

    typedef struct packed {
        esc_state_e         st;
        logic               irq;
        logic               hard;
        logic [RETRY_W-1:0] cnt;
        logic [CNT_W-1:0]   iv;
        logic [CNT_W-1:0]   win;
        logic [BUD_W-1:0]   elapsed;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0]   base_eff;
    logic [RETRY_W-1:0] lim_eff;
    logic [BUD_W-1:0]   bud_eff;
    logic [BUD_W:0]     el_inc;
    logic [CNT_W-1:0]   next_iv;
    logic               set_vld;
    esc_cause_e         set_code;
    esc_cause_e         cause_w;

    wdt_esc_backoff #(.CNT_W(CNT_W)) u_backoff (
        .mode_exp (cfg_exp),
        .cur_win  (ctl_q.iv),
        .base_win (base_eff),
        .next_win (next_iv)
    );

    wdt_esc_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (set_vld),
        .set_code (set_code),
        .clr      (cause_clr),
        .cause    (cause_w)
    );

    always_comb begin
        base_eff = (cfg_base == '0) ? WIN_ONE : cfg_base;
        lim_eff  = (cfg_max_retry == '0) ? RTY_ONE : cfg_max_retry;
        bud_eff  = (cfg_budget == '0) ? BUD_ONE : cfg_budget;
        el_inc   = {1'b0, ctl_q.elapsed} + INC_ONE;

        ctl_d    = ctl_q;
        ctl_d.hard = 1'b0;
        set_vld  = 1'b0;
        set_code = CAUSE_NONE;

        if (irq_ack) ctl_d.irq = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (timeout_evt) begin
                    if (cfg_direct) begin
                        ctl_d.hard = 1'b1;
                        ctl_d.irq  = 1'b0;
                        set_vld    = 1'b1;
                        set_code   = CAUSE_DIRECT;
                    end else begin
                        ctl_d.st      = ST_WAIT;
                        ctl_d.irq     = 1'b1;
                        ctl_d.cnt     = RTY_ONE;
                        ctl_d.iv      = base_eff;
                        ctl_d.win     = base_eff;
                        ctl_d.elapsed = '0;
                    end
                end
            end
            ST_WAIT: begin
                ctl_d.elapsed = el_inc[BUD_W-1:0];
                if (brownout) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.hard = 1'b1;
                    ctl_d.irq  = 1'b0;
                    ctl_d.cnt  = '0;
                    set_vld    = 1'b1;
                    set_code   = CAUSE_BROWN;
                end else if (feed_ok) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.irq = 1'b0;
                    ctl_d.cnt = '0;
                end else if (el_inc >= {1'b0, bud_eff}) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.hard = 1'b1;
                    ctl_d.irq  = 1'b0;
                    ctl_d.cnt  = '0;
                    set_vld    = 1'b1;
                    set_code   = CAUSE_BUDGET;
                end else if (ctl_q.win == WIN_ONE) begin
                    if (ctl_q.cnt >= lim_eff) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.hard = 1'b1;
                        ctl_d.irq  = 1'b0;
                        ctl_d.cnt  = '0;
                        set_vld    = 1'b1;
                        set_code   = CAUSE_EXHAUST;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + RTY_ONE;
                        ctl_d.iv  = next_iv;
                        ctl_d.win = next_iv;
                        ctl_d.irq = 1'b1;
                    end
                end else begin
                    ctl_d.win = ctl_q.win - WIN_ONE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, irq: 1'b0, hard: 1'b0, cnt: '0,
                       iv: '0, win: '0, elapsed: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq            = ctl_q.irq;
    assign hard_reset_req = ctl_q.hard;
    assign retry_cnt      = ctl_q.cnt;
    assign reset_cause    = cause_w;

endmodule

// File: rtl/wdt_esc_chk.sv
module wdt_esc_chk #(
    parameter int RETRY_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               timeout_evt,
    input logic               feed_ok,
    input logic               brownout,
    input logic               cfg_direct,
    input logic               irq_ack,
    input logic               cause_clr,
    input logic               irq,
    input logic               hard_reset_req,
    input logic [RETRY_W-1:0] retry_cnt,
    input logic [2:0]         reset_cause
);
    AST_FIRST_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt == '0 && timeout_evt && !cfg_direct) |=> (irq && retry_cnt == 1 && !hard_reset_req)); // R2
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset_req |=> !hard_reset_req); // R9
    AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset_req |-> (retry_cnt == '0 && !irq)); // R9
    AST_BROWNOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != '0 && brownout) |=> (hard_reset_req && reset_cause == 3'd3)); // R6
    AST_FEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != '0 && !brownout && feed_ok) |=> (retry_cnt == '0 && !irq && !hard_reset_req)); // R7
    AST_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt == '0 && timeout_evt && cfg_direct) |=> (hard_reset_req && !irq && reset_cause == 3'd4)); // R8
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_clr |=> ($stable(reset_cause) || hard_reset_req)); // R10
    AST_CAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cause_clr |=> (reset_cause == 3'd0 || hard_reset_req)); // R10
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> (!irq || retry_cnt != $past(retry_cnt))); // R11
endmodule

bind wdt_escalator wdt_esc_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .timeout_evt    (timeout_evt),
    .feed_ok        (feed_ok),
    .brownout       (brownout),
    .cfg_direct     (cfg_direct),
    .irq_ack        (irq_ack),
    .cause_clr      (cause_clr),
    .irq            (irq),
    .hard_reset_req (hard_reset_req),
    .retry_cnt      (retry_cnt),
    .reset_cause    (reset_cause)
);

// File: tb/tb_wdt_escalator.sv
module tb_wdt_escalator;
    localparam int CNT_W   = 16;
    localparam int RETRY_W = 3;
    localparam int BUD_W   = 20;
    localparam longint SATV = (64'd1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               timeout_evt = 1'b0, feed_ok = 1'b0, brownout = 1'b0;
    logic               cfg_direct = 1'b0, cfg_exp = 1'b0;
    logic [RETRY_W-1:0] cfg_max_retry = '0;
    logic [CNT_W-1:0]   cfg_base = '0;
    logic [BUD_W-1:0]   cfg_budget = '0;
    logic               irq_ack = 1'b0, cause_clr = 1'b0;
    logic               irq, hard_reset_req;
    logic [RETRY_W-1:0] retry_cnt;
    logic [2:0]         reset_cause;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cause = 0;

    wdt_escalator #(.CNT_W(CNT_W), .RETRY_W(RETRY_W), .BUD_W(BUD_W)) dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic longint iv_of(input int base, input bit ex, input int k);
        longint b, v;
        b = (base == 0) ? 1 : base;
        v = ex ? (b << (k - 1)) : b * k;
        return (v > SATV) ? SATV : v;
    endfunction

    // cycles from entry until attempt k starts (k=1 -> 0)
    function automatic longint start_of(input int base, input bit ex, input int k);
        longint s = 0;
        for (int i = 1; i < k; i++) s += iv_of(base, ex, i);
        return s;
    endfunction

    task automatic run_scn(input int base, input bit ex, input int n, input int budget,
                           input bit direct, input longint feed_at, input longint brown_at,
                           input int ack_pct);
        int nl;
        longint bud, sN, t_esc, t, k;
        int cause_esc;
        bit irq_exp, ack;
        chk(reset_cause == exp_cause, "R10 cause held before event", reset_cause, exp_cause);
        cfg_base = CNT_W'(base); cfg_exp = ex; cfg_max_retry = RETRY_W'(n);
        cfg_budget = BUD_W'(budget); cfg_direct = direct;
        timeout_evt = 1'b1;
        @(negedge clk);
        timeout_evt = 1'b0;
        if (direct) begin
            chk(hard_reset_req == 1'b1, "R8 direct request", hard_reset_req, 1);
            chk(irq == 1'b0, "R8 no irq in direct mode", irq, 0);
            chk(reset_cause == 3'd4, "R8 direct cause", reset_cause, 4);
            exp_cause = 4;
            @(negedge clk);
            chk(hard_reset_req == 1'b0, "R9 request one cycle", hard_reset_req, 0);
            return;
        end
        nl = (n == 0) ? 1 : n;
        bud = (budget == 0) ? 1 : budget;
        sN = start_of(base, ex, nl + 1);
        t_esc = (bud <= sN) ? bud : sN;
        cause_esc = (bud <= sN) ? 2 : 1;
        chk(irq == 1'b1 && retry_cnt == 1 && !hard_reset_req, "R2 first event raises irq",
            {irq, retry_cnt, hard_reset_req}, {1'b1, 3'd1, 1'b0});
        irq_exp = 1'b1;
        for (t = 1; t < 200000; t++) begin
            feed_ok = (t == feed_at);
            brownout = (t == brown_at);
            ack = ($urandom_range(99, 0) < ack_pct);
            irq_ack = ack;
            timeout_evt = $urandom_range(1, 0); // R12 ignored while recovering
            @(negedge clk);
            if (t == brown_at) begin
                chk(hard_reset_req && reset_cause == 3'd3, "R6 brownout escalates", reset_cause, 3);
                exp_cause = 3;
                break;
            end else if (t == feed_at) begin
                chk(retry_cnt == 0 && !irq && !hard_reset_req, "R7 feed returns idle",
                    {retry_cnt, irq, hard_reset_req}, 0);
                break;
            end else if (t == t_esc) begin
                chk(hard_reset_req == 1'b1, cause_esc == 2 ? "R5 budget request" : "R4 exhaust request",
                    hard_reset_req, 1);
                chk(reset_cause == cause_esc, cause_esc == 2 ? "R5 budget cause" : "R4 exhaust cause",
                    reset_cause, cause_esc);
                chk(retry_cnt == 0 && !irq, "R9 idle during request", {retry_cnt, irq}, 0);
                exp_cause = cause_esc;
                break;
            end else begin
                k = 1;
                while (start_of(base, ex, int'(k) + 1) <= t) k++;
                if (start_of(base, ex, int'(k)) == t) irq_exp = 1'b1;
                else if (ack) irq_exp = 1'b0;
                chk(retry_cnt == k, "R3 attempt number", retry_cnt, k);
                chk(irq == irq_exp, "R11 irq level", irq, irq_exp);
            end
        end
        feed_ok = 1'b0; brownout = 1'b0; irq_ack = 1'b0; timeout_evt = 1'b0;
        @(negedge clk);
        chk(hard_reset_req == 1'b0 && retry_cnt == 0, "R9 request dropped, idle",
            {hard_reset_req, retry_cnt}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(irq == 0 && hard_reset_req == 0 && retry_cnt == 0 && reset_cause == 0,
            "R1 reset state", {irq, hard_reset_req, retry_cnt, reset_cause}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R7 idle: brownout, feed, ack have no effect
        feed_ok = 1'b1; brownout = 1'b1; irq_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk(!irq && !hard_reset_req && retry_cnt == 0 && reset_cause == 0,
            "R6 R7 idle inputs ignored", {irq, hard_reset_req, retry_cnt, reset_cause}, 0);
        feed_ok = 1'b0; brownout = 1'b0; irq_ack = 1'b0;

        run_scn(5, 1'b0, 3, 1000, 1'b0, -1, -1, 0);   // R3 R4 linear: escalate at 30
        run_scn(3, 1'b1, 3, 1000, 1'b0, -1, -1, 0);   // R3 R4 exponential: 21
        run_scn(4, 1'b0, 2, 12, 1'b0, -1, -1, 0);     // R5 budget ties window end
        run_scn(4, 1'b0, 2, 7, 1'b0, -1, -1, 30);     // R5 budget first
        run_scn(4, 1'b0, 2, 100, 1'b0, 12, -1, 0);    // R7 feed on escalation edge
        run_scn(4, 1'b0, 3, 100, 1'b0, 5, 5, 0);      // R6 brownout beats feed
        run_scn(6, 1'b0, 0, 100, 1'b0, -1, -1, 100);  // R4 limit 0 acts as 1, R11 ack
        run_scn(0, 1'b1, 2, 100, 1'b0, -1, -1, 0);    // R3 base 0 acts as 1
        run_scn(3, 1'b0, 2, 100, 1'b1, -1, -1, 0);    // R8 direct

        // R10 clear: cause_clr alone
        cause_clr = 1'b1;
        @(negedge clk);
        cause_clr = 1'b0;
        chk(reset_cause == 0, "R10 clear", reset_cause, 0);
        exp_cause = 0;

        // R10 clear coinciding with new direct cause: new cause wins
        cfg_direct = 1'b1; timeout_evt = 1'b1; cause_clr = 1'b1;
        @(negedge clk);
        timeout_evt = 1'b0; cause_clr = 1'b0; cfg_direct = 1'b0;
        chk(reset_cause == 3'd4, "R10 new cause beats clear", reset_cause, 4);
        exp_cause = 4;
        @(negedge clk);

        // R3 saturation: exponential 40000 -> 65535
        run_scn(40000, 1'b1, 2, (1 << BUD_W) - 1, 1'b0, -1, -1, 0);

        for (int i = 0; i < 60; i++) begin
            int b, nn, bg, nl2, pick;
            bit ex;
            longint te, fa, ba;
            b = $urandom_range(12, 0);
            ex = $urandom_range(1, 0);
            nn = $urandom_range(4, 0);
            bg = $urandom_range(200, 1);
            nl2 = (nn == 0) ? 1 : nn;
            te = start_of(b, ex, nl2 + 1);
            if (bg < te) te = bg;
            pick = $urandom_range(3, 0);
            fa = (pick == 1 || pick == 3) ? longint'($urandom_range(int'(te) + 3, 1)) : -1;
            ba = (pick == 2 || pick == 3) ? longint'($urandom_range(int'(te) + 3, 1)) : -1;
            run_scn(b, ex, nn, bg, ($urandom_range(9, 0) == 0), fa, ba, $urandom_range(40, 0));
            if ($urandom_range(2, 0) == 0) begin
                cause_clr = 1'b1;
                @(negedge clk);
                cause_clr = 1'b0;
                chk(reset_cause == 0, "R10 random clear", reset_cause, 0);
                exp_cause = 0;
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule